// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single timer channel with a word-addressed register port and one interrupt line. A down-counter moves by one on each prescaled tick of an external timer clock enable. When it passes zero it raises a sticky raw interrupt flag. Depending on the mode it then reloads from a programmed value, wraps to the top of its 16- or 32-bit range, or stops.

Software programs the channel through seven word offsets. Two of them write the same reload register. One also forces the counter to the new value at once. The other leaves the running count alone, so the new value only takes effect at the next wrap. The interrupt line is the raw flag gated by an enable bit, and it is cleared by writing to a dedicated offset.

Top module: `countdown_timer`

## Requirements
- R1: Out of reset the control register reads 0x20: only the interrupt-enable bit (bit 5) is set, so the counter (enable bit 7) is stopped. The raw status reads 0, the irq output is low and the current count reads 0xFFFFFFFF.
- R2: Control bits 3:2 pick the prescale: 00 gives a tick on every timer clock enable, 01 on every 16th and 10 on every 256th; 11 acts as 00. The prescaler counts timer clock enables and restarts from zero on any control write. No tick occurs in the cycle of a control write.
- R3: While enable bit 7 is set, the count (offset 1) decreases by one on each tick and is otherwise unchanged, unless offset 0 is written.
- R4: In periodic mode (bit 6) or one-shot mode (bit 0), the counter starts from the reload value N and expires on the tick that finds it at zero, so one period is N+1 ticks. A periodic counter then reloads N.
- R5: With bits 0 and 6 both clear (free-running), an expiring counter reloads 0xFFFF in 16-bit size or 0xFFFFFFFF in 32-bit size (bit 1 set) and ignores the reload register.
- R6: In one-shot mode an expiry leaves the count unchanged and clears enable bit 7 of the control register, so counting stops.
- R7: A write to offset 0 stores the reload value and loads it into the counter in that same clock, masked to the counter size. A write to offset 6 stores it without touching the count. Both offsets read back the stored value.
- R8: Writes to offset 1 are ignored. Offsets 7 and above (and offset 3 on read) read as zero, and writes to them have no effect. The read data is zero when select is low.
- R9: An expiry sets the raw flag (offset 4, bit 0). Any write to offset 3 clears it, except that an expiry in the same cycle wins.
- R10: The irq output and the masked status (offset 5) equal the raw flag ANDed with control bit 5.
- R11: In 16-bit size (bit 1 clear), expiry is decided on the low 16 bits of the count, and the loads and decrements are masked to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrClkEn | input | 1 | Timer clock enable, one pulse per timer clock |
| sel | input | 1 | Register port select |
| wrEn | input | 1 | Write strobe, qualified by sel |
| wordOff | input | 3 | Register word offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected offset (combinational) |
| irq | output | 1 | Interrupt, raw flag gated by the enable bit |

## Verification
A behavioural model in the bench follows every cycle, and the bench compares the count read-back and irq against it on each clock. The counter runs with a steady timer clock enable, which checks the N+1 period, and with an irregular enable pattern at divide-by-16 and divide-by-256, which checks that only qualifying enables advance the prescaler. Free-running runs in both sizes, one-shot runs and load-zero periodic runs (one expiry on every tick, with clears in the same cycles) check each reload source and the rule that an expiry beats a clear. Loads and writes to the background reload, to the read-only offset and to undefined offsets made while the counter runs show which writes reach the count and which do not.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control bit positions; software relies on them
  localparam int CtlOneShot  = 0;
  localparam int CtlWide     = 1;
  localparam int CtlPsLo     = 2;
  localparam int CtlIntEn    = 5;
  localparam int CtlPeriodic = 6;
  localparam int CtlRun      = 7;
  localparam int CtrlW       = 8;

  // Register word offsets
  localparam logic [2:0] OffLoad   = 3'd0;
  localparam logic [2:0] OffCount  = 3'd1;
  localparam logic [2:0] OffCtrl   = 3'd2;
  localparam logic [2:0] OffIntClr = 3'd3;
  localparam logic [2:0] OffRawSt  = 3'd4;
  localparam logic [2:0] OffMaskSt = 3'd5;
  localparam logic [2:0] OffBgLoad = 3'd6;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadNow;  // store reload value and force the counter
    logic bgLoad;   // store reload value only
    logic intClr;   // clear raw interrupt flag
    logic tick;     // decrement (or expire) this cycle
  } tmrStrobes_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int OFF_W = 3,
  parameter int PS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrClkEn,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  wordOff,
  input  logic [CtrlW-1:0]  wrCtrl,
  input  logic              expire,
  output logic [CtrlW-1:0]  ctrlReg,
  output tmrStrobes_t       strb
);
  localparam logic [PS_W-1:0] PsMax = PS_W'((1 << PS_W) - 1);
  localparam logic [PS_W-1:0] PsMid = PS_W'((1 << (PS_W / 2)) - 1);
  localparam logic [CtrlW-1:0] CtrlRst = CtrlW'(1 << CtlIntEn);

  logic            wr;
  logic            ctrlWr;
  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] psLimit;
  logic            psEnd;

  assign wr     = sel & wrEn;
  assign ctrlWr = wr && (wordOff == OFF_W'(OffCtrl));

  always_comb begin
    case (ctrlReg[CtlPsLo +: 2])
      2'b01:   psLimit = PsMid;
      2'b10:   psLimit = PsMax;
      default: psLimit = '0;
    endcase
  end

  assign psEnd = (psCnt == psLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (ctrlWr) begin
      psCnt <= '0;
    end else if (tmrClkEn) begin
      psCnt <= psEnd ? '0 : psCnt + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CtrlRst;
    end else if (ctrlWr) begin
      ctrlReg <= wrCtrl;
    end else if (expire && ctrlReg[CtlOneShot]) begin
      ctrlReg[CtlRun] <= 1'b0;
    end
  end

  always_comb begin
    strb.loadNow = wr && (wordOff == OFF_W'(OffLoad));
    strb.bgLoad  = wr && (wordOff == OFF_W'(OffBgLoad));
    strb.intClr  = wr && (wordOff == OFF_W'(OffIntClr));
    strb.tick    = ctrlReg[CtlRun] && tmrClkEn && psEnd && !ctrlWr;
  end

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire && ctrlReg[CtlOneShot] |=> !ctrlReg[CtlRun]);

  // R2
  slow_prescale_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick && (ctrlReg[CtlPsLo +: 2] == 2'b10) |=> !strb.tick);

  // R2
  ctrl_write_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |-> !strb.tick);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strb,
  input  logic [CtrlW-1:0]  ctrlReg,
  input  logic              sel,
  input  logic [OFF_W-1:0]  wordOff,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              expire
);
  localparam int HalfW = DATA_W / 2;
  localparam logic [DATA_W-1:0] HalfMask = {{(DATA_W - HalfW){1'b0}}, {HalfW{1'b1}}};

  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] count;
  logic              rawFlag;
  logic [DATA_W-1:0] sizeMask;
  logic              freeRun;
  logic              intOut;
  logic [DATA_W-1:0] rdVal;

  assign sizeMask = ctrlReg[CtlWide] ? '1 : HalfMask;
  assign freeRun  = !ctrlReg[CtlOneShot] && !ctrlReg[CtlPeriodic];
  assign expire   = strb.tick && ((count & sizeMask) == '0);
  assign intOut   = rawFlag & ctrlReg[CtlIntEn];
  assign irq      = intOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal <= '0;
    end else if (strb.loadNow || strb.bgLoad) begin
      loadVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '1;
    end else if (strb.loadNow) begin
      count <= wrData & sizeMask;
    end else if (expire) begin
      if (!ctrlReg[CtlOneShot]) begin
        count <= freeRun ? sizeMask : (loadVal & sizeMask);
      end
    end else if (strb.tick) begin
      count <= (count - DATA_W'(1)) & sizeMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawFlag <= 1'b0;
    end else if (expire) begin
      rawFlag <= 1'b1;
    end else if (strb.intClr) begin
      rawFlag <= 1'b0;
    end
  end

  always_comb begin
    case (wordOff)
      OFF_W'(OffLoad), OFF_W'(OffBgLoad): rdVal = loadVal;
      OFF_W'(OffCount):  rdVal = count;
      OFF_W'(OffCtrl):   rdVal = {{(DATA_W - CtrlW){1'b0}}, ctrlReg};
      OFF_W'(OffRawSt):  rdVal = {{(DATA_W - 1){1'b0}}, rawFlag};
      OFF_W'(OffMaskSt): rdVal = {{(DATA_W - 1){1'b0}}, intOut};
      default:           rdVal = '0;
    endcase
  end

  assign rdData = sel ? rdVal : '0;

  // R7
  load_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNow |=> count == $past(wrData & sizeMask));

  // R9
  raw_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> rawFlag);

  // R9
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.intClr && !expire |=> !rawFlag);

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick && !strb.loadNow |=> $stable(count));
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 3,
  parameter int PS_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrClkEn,
  input  logic              sel,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  wordOff,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  tmrStrobes_t      strb;
  logic [CtrlW-1:0] ctrlReg;
  logic             expire;

  tmr_ctrl #(.OFF_W(OFF_W), .PS_W(PS_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tmrClkEn (tmrClkEn),
    .sel      (sel),
    .wrEn     (wrEn),
    .wordOff  (wordOff),
    .wrCtrl   (wrData[CtrlW-1:0]),
    .expire   (expire),
    .ctrlReg  (ctrlReg),
    .strb     (strb)
  );

  tmr_datapath #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .ctrlReg (ctrlReg),
    .sel     (sel),
    .wordOff (wordOff),
    .wrData  (wrData),
    .rdData  (rdData),
    .irq     (irq),
    .expire  (expire)
  );
endmodule

// File: tb/countdown_timer_tb.sv
module countdown_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tmrClkEn = 1'b0;
  logic        sel = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wordOff = 3'd0;
  logic [31:0] wrData = 32'd0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rndEn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [7:0]  mCtrl  = 8'h20;
  logic [31:0] mLoad  = 32'd0;
  logic [31:0] mCount = 32'hFFFF_FFFF;
  logic        mRaw   = 1'b0;
  int          mPs    = 0;

  always #2.5 clk = ~clk;

  countdown_timer u_dut (
    .clk(clk), .rstN(rstN), .tmrClkEn(tmrClkEn), .sel(sel), .wrEn(wrEn),
    .wordOff(wordOff), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] mRead(input logic [2:0] off);
    case (off)
      3'd0, 3'd6: return mLoad;
      3'd1:       return mCount;
      3'd2:       return {24'd0, mCtrl};
      3'd4:       return {31'd0, mRaw};
      3'd5:       return {31'd0, mRaw & mCtrl[5]};
      default:    return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] off);
    case (off)
      3'd0, 3'd6: return "R7";
      3'd1:       return "R3";
      3'd2:       return "R6";
      3'd4:       return "R9";
      3'd5:       return "R10";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare outputs against the model with the inputs now on the pins
  task automatic compareModel();
    if (sel) check(tagFor(wordOff), rdData, mRead(wordOff));
    check("R10 irq", {31'd0, irq}, {31'd0, mRaw & mCtrl[5]});
  endtask

  task automatic modelStep();
    logic wr, ctlW, psEnd, tick, expv;
    logic [31:0] mask;
    int div;
    wr   = sel & wrEn;
    ctlW = wr && (wordOff == 3'd2);
    case (mCtrl[3:2])
      2'b01:   div = 16;
      2'b10:   div = 256;
      default: div = 1;
    endcase
    psEnd = (mPs == div - 1);
    tick  = mCtrl[7] && tmrClkEn && psEnd && !ctlW;
    mask  = mCtrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    expv  = tick && ((mCount & mask) == 32'd0);
    if (wr && wordOff == 3'd0) mCount = wrData & mask;
    else if (expv) begin
      if (!mCtrl[0]) mCount = (!mCtrl[6]) ? mask : (mLoad & mask);
    end else if (tick) mCount = (mCount - 32'd1) & mask;
    if (expv) mRaw = 1'b1;
    else if (wr && wordOff == 3'd3) mRaw = 1'b0;
    if (wr && (wordOff == 3'd0 || wordOff == 3'd6)) mLoad = wrData;
    if (ctlW) mCtrl = wrData[7:0];
    else if (expv && mCtrl[0]) mCtrl[7] = 1'b0;
    if (ctlW) mPs = 0;
    else if (tmrClkEn) mPs = psEnd ? 0 : mPs + 1;
  endtask

  task automatic drive(input logic s, input logic w, input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tmrClkEn = rndEn ? lfsr[0] : 1'b1;
    sel = s; wrEn = w; wordOff = off; wrData = d;
    #1;
    compareModel();
  endtask

  task automatic advance();
    @(posedge clk);
    modelStep();
  endtask

  task automatic wr32(input logic [2:0] off, input logic [31:0] d);
    drive(1'b1, 1'b1, off, d);
    advance();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, 1'b0, 3'd1, 32'd0);
      advance();
    end
  endtask

  task automatic expectRead(input string tag, input logic [2:0] off, input logic [31:0] exp);
    drive(1'b1, 1'b0, off, 32'd0);
    check(tag, rdData, exp);
    advance();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectRead("R1 ctrl", 3'd2, 32'h20);
    expectRead("R1 raw", 3'd4, 32'd0);
    expectRead("R1 count", 3'd1, 32'hFFFF_FFFF);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R7 immediate and background reload, counter stopped
    wr32(3'd0, 32'd5);
    expectRead("R7 load forces count", 3'd1, 32'd5);
    wr32(3'd6, 32'd9);
    expectRead("R7 bg load keeps count", 3'd1, 32'd5);
    expectRead("R7 readback off0", 3'd0, 32'd9);
    expectRead("R7 readback off6", 3'd6, 32'd9);

    // R8 ignored writes
    wr32(3'd1, 32'hDEAD_BEEF);
    expectRead("R8 count untouched", 3'd1, 32'd5);
    wr32(3'd7, 32'h1234_5678);
    expectRead("R8 undefined off", 3'd7, 32'd0);
    expectRead("R8 clear reads zero", 3'd3, 32'd0);
    drive(1'b0, 1'b0, 3'd0, 32'd0);
    check("R8 deselected read", rdData, 32'd0);
    advance();

    // R4 periodic 32-bit, divide by 1: 5 then reload from bg value 9
    wr32(3'd2, 32'hE2);
    idle(7);
    expectRead("R9 raw set", 3'd4, 32'd1);
    check("R10 irq high", {31'd0, irq}, 32'd1);
    idle(12);
    wr32(3'd3, 32'd0);
    expectRead("R9 raw cleared", 3'd4, 32'd0);

    // R10 masked status with interrupt disabled
    wr32(3'd2, 32'hC2);
    idle(12);
    expectRead("R10 raw still set", 3'd4, 32'd1);
    expectRead("R10 masked zero", 3'd5, 32'd0);
    check("R10 irq low", {31'd0, irq}, 32'd0);

    // R2 prescalers with irregular timer enables; writes during running
    rndEn = 1'b1;
    wr32(3'd0, 32'd3);
    wr32(3'd2, 32'hE6);
    idle(200);
    wr32(3'd6, 32'd1);
    wr32(3'd1, 32'd77);
    idle(150);
    wr32(3'd2, 32'hEA);
    idle(1200);
    rndEn = 1'b0;

    // R5 free-running 16-bit then 32-bit
    wr32(3'd2, 32'h80);
    wr32(3'd0, 32'd2);
    idle(3);
    expectRead("R5 wrap 16-bit", 3'd1, 32'h0000_FFFF);
    wr32(3'd2, 32'h82);
    wr32(3'd0, 32'd1);
    idle(2);
    expectRead("R5 wrap 32-bit", 3'd1, 32'hFFFF_FFFF);

    // R11 16-bit masking of loads
    wr32(3'd2, 32'h20);
    wr32(3'd0, 32'h0001_2345);
    expectRead("R11 masked load", 3'd1, 32'h0000_2345);

    // R6 one-shot
    wr32(3'd3, 32'd0);
    wr32(3'd2, 32'hA3);
    wr32(3'd0, 32'd4);
    idle(12);
    expectRead("R6 count held", 3'd1, 32'd0);
    expectRead("R6 enable cleared", 3'd2, 32'h23);
    expectRead("R4 one-shot raw", 3'd4, 32'd1);

    // R9 expiry beats clear: load 0 periodic expires every tick
    wr32(3'd2, 32'hE2);
    wr32(3'd0, 32'd0);
    for (int i = 0; i < 6; i++) wr32(3'd3, 32'd0);
    expectRead("R9 expiry wins", 3'd4, 32'd1);
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule